// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps a small state machine for every hardware thread of a multithreaded fetch stage and advances it once per clock. Each cycle it looks at the events aimed at the thread and picks one next state in a fixed priority order. The events are block and unblock pulses from the four downstream stages, squash requests from commit and decode, a reorder-buffer-still-squashing flag, trap, quiesce and wake events, the thread's fetch slot, and the outcome of instruction-cache sends, retries and responses. The block reports each thread's state code and a single flag that says whether the fetch stage has useful work.

The block owns the one retry slot that all threads share. When the cache rejects a request, the sending thread takes the slot and new sends are held off until a retry or a squash frees it. Every cache request carries a small per-thread tag. A response is taken only if it carries the current tag and its thread is still waiting. Any other response is dropped and counted, so an answer to a cancelled or superseded request can never wake a thread.

Top module: `fetch_thread_status`

## Requirements
- R1: After reset every thread is Running, every request tag is 0, the retry slot is free and the drop count is 0. State codes on `threadStatus` (4 bits per thread, thread t at bits 4t+3..4t) are: 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 TrapPending, 5 QuiescePending, 6 WaitResponse, 7 WaitRetry, 8 LineReady.
- R2: Each thread has four sticky stall bits, one per downstream stage, at `stallSet`/`stallClr` bit 4t+s. A set pulse sets the bit and a clear pulse clears it. A set pulse and a clear pulse for the same bit never arrive together, and a clear pulse only arrives when the bit is set. In the same cycle, a thread with any bit set, or with `ctxSwitch` high, goes to Blocked, unless it is in WaitResponse, WaitRetry, TrapPending or QuiescePending.
- R3: A thread in Blocked or Squashing goes back to Running on the next clock when no squash, stall, trap or quiesce event applies to it.
- R4: A commit squash wins over every other event and moves the thread to Squashing. The thread then drops any response still outstanding for it, and if the thread owns the retry slot the slot is freed (`cacheBlocked` falls).
- R5: A reorder-buffer-squashing flag forces Squashing. A decode squash moves the thread to Squashing only when it is not already Squashing. A decode squash that arrives while the thread is Squashing has no effect, and the thread returns to Running.
- R6: A send (`sendValid`, `sendTid`) from a Running thread increments that thread's 3-bit tag, which wraps. If `sendAccept` is high the thread moves to WaitResponse.
- R7: A rejected send moves the thread to WaitRetry, hands it the retry slot and raises `cacheBlocked`. While the slot is taken, no thread sends. `retryOk` moves the owner to WaitResponse and frees the slot. The tag does not change on a retry.
- R8: A response is accepted only when its thread is in WaitResponse, `respTag` equals that thread's current tag, and no squash applies to the thread in that cycle. Every other response increments `dropCount` by one and leaves the state unchanged.
- R9: An accepted response moves the thread to Blocked if it has a stall, and otherwise to LineReady. LineReady becomes Running when `fetchSlot` is high for the thread.
- R10: A trap or quiesce event moves a thread that is not in WaitResponse, WaitRetry, TrapPending or QuiescePending to TrapPending or QuiescePending, with trap taking precedence. This event outranks a stall. `wakeEv` returns TrapPending or QuiescePending to Running.
- R11: `stageActive` is high exactly when some thread whose `activeMask` bit is set is in Running, Squashing or LineReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activeMask | input | NT | Threads that count toward stage activity |
| stallSet | input | 4*NT | Stall set pulses, bit 4t+s |
| stallClr | input | 4*NT | Stall clear pulses, bit 4t+s |
| ctxSwitch | input | 1 | Global stall for all threads |
| commitSquash | input | NT | Squash request from commit |
| robSquashing | input | NT | Reorder buffer still squashing |
| decodeSquash | input | NT | Squash request from decode |
| trapEv | input | NT | Trap event |
| quiesceEv | input | NT | Quiesce event |
| wakeEv | input | NT | Leave trap or quiesce wait |
| fetchSlot | input | NT | Thread holds the fetch slot this cycle |
| sendValid | input | 1 | A cache request is sent |
| sendTid | input | TID_W | Thread of the send |
| sendAccept | input | 1 | Cache took the send |
| retryOk | input | 1 | Resend from the retry slot succeeded |
| respValid | input | 1 | Cache response arrives |
| respTid | input | TID_W | Thread of the response |
| respTag | input | TAG_W | Tag carried by the response |
| threadStatus | output | 4*NT | State code per thread |
| reqTag | output | TAG_W*NT | Current request tag per thread |
| cacheBlocked | output | 1 | Retry slot taken |
| dropCount | output | CNT_W | Dropped responses, wrapping |
| stageActive | output | 1 | Fetch stage has work |

## Verification
Every state is registered, so a wrong next-state choice shows on `threadStatus` one clock after the events that caused it. A lost or stuck stall bit appears as a thread that leaves Blocked too early or stays in it too long. A wrong tag or retry-slot update is harder to see, because nothing changes when it happens. It shows later, when a response is dropped and should have been taken (or the reverse), which is visible on `dropCount` and on the state of the thread waiting for it. `cacheBlocked` can also stay high with no thread left in WaitRetry.

// File: rtl/fetch_status_pkg.sv
package fetch_status_pkg;

  localparam int STAGE_CNT = 4;

  typedef enum logic [3:0] {
    ST_RUN       = 4'd0,
    ST_IDLE      = 4'd1,
    ST_SQUASH    = 4'd2,
    ST_BLOCK     = 4'd3,
    ST_TRAP      = 4'd4,
    ST_QUIESCE   = 4'd5,
    ST_WAITRESP  = 4'd6,
    ST_WAITRETRY = 4'd7,
    ST_LINEREADY = 4'd8
  } fstate_e;

  // Per-thread strobes from control to the tracking datapath.
  typedef struct packed {
    logic tagBump;
    logic slotTake;
    logic slotFree;
    logic dropResp;
  } fstrobe_t;

endpackage

// File: rtl/fetch_track_dp.sv
module fetch_track_dp
  import fetch_status_pkg::*;
#(
  parameter int NT    = 2,
  parameter int TAG_W = 3,
  parameter int CNT_W = 8,
  parameter int TID_W = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NT*STAGE_CNT-1:0]   stallSet,
  input  logic [NT*STAGE_CNT-1:0]   stallClr,
  input  logic                      ctxSwitch,
  input  fstrobe_t [NT-1:0]         strobes,
  output logic [NT-1:0]             stallAny,
  output logic [NT*TAG_W-1:0]       tagVec,
  output logic                      slotValid,
  output logic [TID_W-1:0]          slotTid,
  output logic [CNT_W-1:0]          dropCount
);

  logic [NT*STAGE_CNT-1:0] stallQ, stallD;
  logic                    slotValidD;
  logic [TID_W-1:0]        slotTidD;
  logic [CNT_W-1:0]        dropInc;

  // Sticky stall bits; the check uses this cycle's updated value.
  assign stallD = (stallQ | stallSet) & ~stallClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallQ <= '0;
    else       stallQ <= stallD;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [TAG_W-1:0] tagQ;
    assign stallAny[t] = (|stallD[t*STAGE_CNT +: STAGE_CNT]) | ctxSwitch;
    assign tagVec[t*TAG_W +: TAG_W] = tagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 tagQ <= '0;
      else if (strobes[t].tagBump) tagQ <= tagQ + 1'b1;
    end
  end

  // Shared retry slot: a free and a take never meet in one cycle.
  always_comb begin
    slotValidD = slotValid;
    slotTidD   = slotTid;
    dropInc    = '0;
    for (int t = 0; t < NT; t++) begin
      if (strobes[t].slotFree) slotValidD = 1'b0;
      dropInc = dropInc + CNT_W'(strobes[t].dropResp);
    end
    for (int t = 0; t < NT; t++) begin
      if (strobes[t].slotTake) begin
        slotValidD = 1'b1;
        slotTidD   = TID_W'(t);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      slotTid   <= '0;
      dropCount <= '0;
    end else begin
      slotValid <= slotValidD;
      slotTid   <= slotTidD;
      dropCount <= dropCount + dropInc;
    end
  end

endmodule

// File: rtl/fetch_status_fsm.sv
module fetch_status_fsm
  import fetch_status_pkg::*;
#(
  parameter int NT    = 2,
  parameter int TAG_W = 3,
  parameter int TID_W = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NT-1:0]         commitSquash,
  input  logic [NT-1:0]         robSquashing,
  input  logic [NT-1:0]         decodeSquash,
  input  logic [NT-1:0]         trapEv,
  input  logic [NT-1:0]         quiesceEv,
  input  logic [NT-1:0]         wakeEv,
  input  logic [NT-1:0]         fetchSlot,
  input  logic                  sendValid,
  input  logic [TID_W-1:0]      sendTid,
  input  logic                  sendAccept,
  input  logic                  retryOk,
  input  logic                  respValid,
  input  logic [TID_W-1:0]      respTid,
  input  logic [TAG_W-1:0]      respTag,
  input  logic [NT-1:0]         stallAny,
  input  logic [NT*TAG_W-1:0]   tagVec,
  input  logic                  slotValid,
  input  logic [TID_W-1:0]      slotTid,
  output logic [NT*4-1:0]       threadStatus,
  output fstrobe_t [NT-1:0]     strobes
);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fstate_e  cur, nxt;
    fstrobe_t sb;
    logic owns, sendMine, respMine, respHit, squashNow, stallable;

    always_comb begin
      owns      = slotValid && (slotTid == TID_W'(t));
      sendMine  = sendValid && (sendTid == TID_W'(t));
      respMine  = respValid && (respTid == TID_W'(t));
      respHit   = respMine && (cur == ST_WAITRESP) &&
                  (respTag == tagVec[t*TAG_W +: TAG_W]);
      squashNow = commitSquash[t] | robSquashing[t] |
                  (decodeSquash[t] && (cur != ST_SQUASH));
      stallable = !(cur inside {ST_WAITRESP, ST_WAITRETRY, ST_TRAP, ST_QUIESCE});
      nxt = cur;
      sb  = '0;
      if (squashNow) begin
        nxt         = ST_SQUASH;
        sb.slotFree = owns;
      end else if (respHit) begin
        nxt = stallAny[t] ? ST_BLOCK : ST_LINEREADY;
      end else if ((trapEv[t] || quiesceEv[t]) && stallable) begin
        nxt = trapEv[t] ? ST_TRAP : ST_QUIESCE;
      end else if (stallAny[t] && stallable) begin
        nxt = ST_BLOCK;
      end else if (cur == ST_BLOCK || cur == ST_SQUASH) begin
        nxt = ST_RUN;
      end else if (wakeEv[t] && (cur == ST_TRAP || cur == ST_QUIESCE)) begin
        nxt = ST_RUN;
      end else if (cur == ST_LINEREADY && fetchSlot[t]) begin
        nxt = ST_RUN;
      end else if (cur == ST_RUN && sendMine) begin
        sb.tagBump = 1'b1;
        if (sendAccept) begin
          nxt = ST_WAITRESP;
        end else begin
          nxt         = ST_WAITRETRY;
          sb.slotTake = 1'b1;
        end
      end else if (cur == ST_WAITRETRY && owns && retryOk) begin
        nxt         = ST_WAITRESP;
        sb.slotFree = 1'b1;
      end
      sb.dropResp = respMine && !(respHit && !squashNow);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= ST_RUN;
      else       cur <= nxt;
    end

    assign threadStatus[t*4 +: 4] = cur;
    assign strobes[t]             = sb;
  end

endmodule

// File: rtl/fetch_thread_status.sv
module fetch_thread_status
  import fetch_status_pkg::*;
#(
  parameter int NT    = 2,
  parameter int TAG_W = 3,
  parameter int CNT_W = 8,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NT-1:0]            activeMask,
  input  logic [NT*STAGE_CNT-1:0]  stallSet,
  input  logic [NT*STAGE_CNT-1:0]  stallClr,
  input  logic                     ctxSwitch,
  input  logic [NT-1:0]            commitSquash,
  input  logic [NT-1:0]            robSquashing,
  input  logic [NT-1:0]            decodeSquash,
  input  logic [NT-1:0]            trapEv,
  input  logic [NT-1:0]            quiesceEv,
  input  logic [NT-1:0]            wakeEv,
  input  logic [NT-1:0]            fetchSlot,
  input  logic                     sendValid,
  input  logic [TID_W-1:0]         sendTid,
  input  logic                     sendAccept,
  input  logic                     retryOk,
  input  logic                     respValid,
  input  logic [TID_W-1:0]         respTid,
  input  logic [TAG_W-1:0]         respTag,
  output logic [NT*4-1:0]          threadStatus,
  output logic [NT*TAG_W-1:0]      reqTag,
  output logic                     cacheBlocked,
  output logic [CNT_W-1:0]         dropCount,
  output logic                     stageActive
);

  fstrobe_t [NT-1:0] strobes;
  logic [NT-1:0]     stallAny;
  logic              slotValid;
  logic [TID_W-1:0]  slotTid;

  fetch_track_dp #(.NT(NT), .TAG_W(TAG_W), .CNT_W(CNT_W), .TID_W(TID_W)) uDp (
    .clk(clk), .rstN(rstN), .stallSet(stallSet), .stallClr(stallClr),
    .ctxSwitch(ctxSwitch), .strobes(strobes), .stallAny(stallAny),
    .tagVec(reqTag), .slotValid(slotValid), .slotTid(slotTid),
    .dropCount(dropCount)
  );

  fetch_status_fsm #(.NT(NT), .TAG_W(TAG_W), .TID_W(TID_W)) uFsm (
    .clk(clk), .rstN(rstN), .commitSquash(commitSquash),
    .robSquashing(robSquashing), .decodeSquash(decodeSquash),
    .trapEv(trapEv), .quiesceEv(quiesceEv), .wakeEv(wakeEv),
    .fetchSlot(fetchSlot), .sendValid(sendValid), .sendTid(sendTid),
    .sendAccept(sendAccept), .retryOk(retryOk), .respValid(respValid),
    .respTid(respTid), .respTag(respTag), .stallAny(stallAny),
    .tagVec(reqTag), .slotValid(slotValid), .slotTid(slotTid),
    .threadStatus(threadStatus), .strobes(strobes)
  );

  assign cacheBlocked = slotValid;

  always_comb begin
    stageActive = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (activeMask[t] && (threadStatus[t*4 +: 4] inside
          {ST_RUN, ST_SQUASH, ST_LINEREADY}))
        stageActive = 1'b1;
    end
  end

endmodule

// File: rtl/fetch_thread_status_chk.sv
module fetch_thread_status_chk #(
  parameter int NT    = 2,
  parameter int TAG_W = 3,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NT*4-1:0]      stallSet,
  input logic [NT*4-1:0]      stallClr,
  input logic [NT-1:0]        commitSquash,
  input logic                 respValid,
  input logic [NT*4-1:0]      threadStatus,
  input logic [NT*TAG_W-1:0]  reqTag,
  input logic                 cacheBlocked,
  input logic [CNT_W-1:0]     dropCount
);

  int nRetry;
  always_comb begin
    nRetry = 0;
    for (int t = 0; t < NT; t++)
      if (threadStatus[t*4 +: 4] == 4'd7) nRetry = nRetry + 1;
  end

  a_r2_pulse_protocol: assert property (@(posedge clk) disable iff (!rstN)
    (stallSet & stallClr) == '0);

  a_r7_slot_owner: assert property (@(posedge clk) disable iff (!rstN)
    cacheBlocked == (nRetry == 1));

  a_r7_single_waiter: assert property (@(posedge clk) disable iff (!rstN)
    nRetry <= 1);

  a_r8_drop_needs_resp: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |=> $stable(dropCount));

  for (genvar t = 0; t < NT; t++) begin : g_thr
    a_r4_commit_wins: assert property (@(posedge clk) disable iff (!rstN)
      commitSquash[t] |=> threadStatus[t*4 +: 4] == 4'd2);

    a_r9_ready_from_wait: assert property (@(posedge clk) disable iff (!rstN)
      (threadStatus[t*4 +: 4] == 4'd8 && $past(threadStatus[t*4 +: 4]) != 4'd8)
      |-> $past(threadStatus[t*4 +: 4]) == 4'd6);

    a_r6_tag_step: assert property (@(posedge clk) disable iff (!rstN)
      (reqTag[t*TAG_W +: TAG_W] != $past(reqTag[t*TAG_W +: TAG_W]))
      |-> reqTag[t*TAG_W +: TAG_W] == TAG_W'($past(reqTag[t*TAG_W +: TAG_W]) + 1));
  end

endmodule

bind fetch_thread_status fetch_thread_status_chk #(
  .NT(NT), .TAG_W(TAG_W), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .stallSet(stallSet), .stallClr(stallClr),
  .commitSquash(commitSquash), .respValid(respValid),
  .threadStatus(threadStatus), .reqTag(reqTag),
  .cacheBlocked(cacheBlocked), .dropCount(dropCount)
);

// File: tb/tb_fetch_thread_status.sv
module tb_fetch_thread_status;
  localparam int NT = 2, TAG_W = 3, CNT_W = 8, TID_W = 1;
  localparam int S_RUN = 0, S_SQ = 2, S_BLK = 3, S_TRAP = 4, S_QUI = 5,
                 S_WRESP = 6, S_WRETRY = 7, S_READY = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NT-1:0] activeMask;
  logic [NT*4-1:0] stallSet, stallClr;
  logic ctxSwitch, sendValid, sendAccept, retryOk, respValid;
  logic [NT-1:0] commitSquash, robSquashing, decodeSquash, trapEv, quiesceEv, wakeEv, fetchSlot;
  logic [TID_W-1:0] sendTid, respTid;
  logic [TAG_W-1:0] respTag;
  logic [NT*4-1:0] threadStatus;
  logic [NT*TAG_W-1:0] reqTag;
  logic cacheBlocked, stageActive;
  logic [CNT_W-1:0] dropCount;

  fetch_thread_status #(.NT(NT), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // Reference model state
  int mSt[NT];
  bit [3:0] mStall[NT];
  int mTag[NT];
  bit mSlotV;
  int mSlotT;
  int mDrop;

  task automatic check(bit ok, string lbl, string what, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", lbl, what, got, exp);
    end
  endtask

  task automatic clearPulses();
    stallSet = '0; stallClr = '0; ctxSwitch = 0;
    commitSquash = '0; robSquashing = '0; decodeSquash = '0;
    trapEv = '0; quiesceEv = '0; wakeEv = '0; fetchSlot = '0;
    sendValid = 0; sendTid = '0; sendAccept = 0; retryOk = 0;
    respValid = 0; respTid = '0; respTag = '0;
  endtask

  task automatic modelStep();
    bit freeS, takeS;
    int takeT, s;
    bit stl, own, sq, rmine, hit, hold;
    freeS = 0; takeS = 0; takeT = 0;
    for (int t = 0; t < NT; t++) begin
      mStall[t] = (mStall[t] | stallSet[t*4 +: 4]) & ~stallClr[t*4 +: 4];
      stl   = (mStall[t] != 0) || ctxSwitch;
      s     = mSt[t];
      own   = mSlotV && mSlotT == t;
      sq    = commitSquash[t] || robSquashing[t] || (decodeSquash[t] && s != S_SQ);
      rmine = respValid && int'(respTid) == t;
      hit   = rmine && s == S_WRESP && int'(respTag) == mTag[t] && !sq;
      hold  = (s == S_WRESP) || (s == S_WRETRY) || (s == S_TRAP) || (s == S_QUI);
      if (rmine && !hit) mDrop = (mDrop + 1) % (1 << CNT_W);
      if (sq) begin
        mSt[t] = S_SQ;
        if (own) freeS = 1;
      end else if (hit) mSt[t] = stl ? S_BLK : S_READY;
      else if ((trapEv[t] || quiesceEv[t]) && !hold) mSt[t] = trapEv[t] ? S_TRAP : S_QUI;
      else if (stl && !hold) mSt[t] = S_BLK;
      else if (s == S_BLK || s == S_SQ) mSt[t] = S_RUN;
      else if (wakeEv[t] && (s == S_TRAP || s == S_QUI)) mSt[t] = S_RUN;
      else if (s == S_READY && fetchSlot[t]) mSt[t] = S_RUN;
      else if (s == S_RUN && sendValid && int'(sendTid) == t) begin
        mTag[t] = (mTag[t] + 1) % (1 << TAG_W);
        if (sendAccept) mSt[t] = S_WRESP;
        else begin mSt[t] = S_WRETRY; takeS = 1; takeT = t; end
      end else if (s == S_WRETRY && own && retryOk) begin
        mSt[t] = S_WRESP; freeS = 1;
      end
    end
    if (freeS) mSlotV = 0;
    if (takeS) begin mSlotV = 1; mSlotT = takeT; end
  endtask

  task automatic compare(string lbl);
    bit act;
    act = 0;
    for (int t = 0; t < NT; t++) begin
      check(int'(threadStatus[t*4 +: 4]) == mSt[t], lbl, $sformatf("status[%0d]", t),
            int'(threadStatus[t*4 +: 4]), mSt[t]);
      check(int'(reqTag[t*TAG_W +: TAG_W]) == mTag[t], lbl, $sformatf("tag[%0d]", t),
            int'(reqTag[t*TAG_W +: TAG_W]), mTag[t]);
      if (activeMask[t] && (mSt[t] == S_RUN || mSt[t] == S_SQ || mSt[t] == S_READY)) act = 1;
    end
    check(cacheBlocked == mSlotV, lbl, "cacheBlocked", int'(cacheBlocked), int'(mSlotV));
    check(int'(dropCount) == mDrop, lbl, "dropCount", int'(dropCount), mDrop);
    check(stageActive == act, $sformatf("R11 (%s)", lbl), "stageActive", int'(stageActive), int'(act));
  endtask

  task automatic step(string lbl);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compare(lbl);
    clearPulses();
  endtask

  task automatic send(int t, bit acc);
    sendValid = 1; sendTid = TID_W'(t); sendAccept = acc;
  endtask

  task automatic resp(int t, int tag);
    respValid = 1; respTid = TID_W'(t); respTag = TAG_W'(tag);
  endtask

  task automatic randomInputs();
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < 4; s++) begin
        if ($urandom_range(15) == 0) stallSet[t*4+s] = 1;
        else if (mStall[t][s] && $urandom_range(3) == 0) stallClr[t*4+s] = 1;
      end
      commitSquash[t] = ($urandom_range(31) == 0);
      robSquashing[t] = ($urandom_range(31) == 0);
      decodeSquash[t] = ($urandom_range(15) == 0);
      trapEv[t]       = ($urandom_range(39) == 0);
      quiesceEv[t]    = ($urandom_range(39) == 0);
      wakeEv[t]       = ($urandom_range(3) == 0);
      fetchSlot[t]    = ($urandom_range(1) == 0);
    end
    ctxSwitch = ($urandom_range(31) == 0);
    if (!mSlotV && $urandom_range(1) == 0) send(int'($urandom_range(NT-1)), $urandom_range(3) != 0);
    retryOk = ($urandom_range(3) == 0);
    if ($urandom_range(2) == 0) begin
      int rt;
      rt = int'($urandom_range(NT-1));
      resp(rt, ($urandom_range(3) == 0) ? mTag[rt] + 7 : mTag[rt]);
    end
    if ($urandom_range(15) == 0) activeMask = NT'($urandom_range((1 << NT) - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    activeMask = '1;
    clearPulses();
    for (int t = 0; t < NT; t++) begin mSt[t] = S_RUN; mStall[t] = 0; mTag[t] = 0; end
    mSlotV = 0; mSlotT = 0; mDrop = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    compare("R1 reset");

    // R2 sticky stall bits and R3 return to Running
    stallSet[1] = 1;          step("R2 rename stall t0");
                              step("R2 stall stays sticky");
    stallClr[1] = 1;          step("R3 unblock returns to run");
    ctxSwitch = 1;            step("R2 global stall");
                              step("R3 both back to run");
    // R6 send, R8 tag match, R9 response result
    send(0, 1);               step("R6 accepted send");
    stallSet[0] = 1;          step("R2 wait-response ignores stall");
    resp(0, 0);               step("R8 stale tag dropped");
    resp(0, 1);               step("R9 response with stall -> blocked");
    stallClr[0] = 1;          step("R3 unblock");
    send(0, 1);               step("R6 second send");
    resp(0, 2);               step("R9 response -> line ready");
                              step("R9 waits for fetch slot");
    fetchSlot[0] = 1;         step("R9 fetch slot -> run");
    // R7 retry slot
    send(1, 0);               step("R7 rejected send takes slot");
                              step("R7 slot held");
    retryOk = 1;              step("R7 retry frees slot");
    // R4 commit squash
    commitSquash[1] = 1;      step("R4 commit squash cancels wait");
    resp(1, 1);               step("R8 response after squash dropped");
    send(1, 0);               step("R7 reject again");
    commitSquash[1] = 1; stallSet[4] = 1; step("R4 squash frees slot over stall");
                              step("R2 stall after squash");
    stallClr[4] = 1;          step("R3 back to run");
    // R5 squash sources
    robSquashing[0] = 1;      step("R5 rob squashing");
    decodeSquash[0] = 1;      step("R5 decode squash ignored while squashing");
    decodeSquash[0] = 1;      step("R5 decode squash from run");
                              step("R3 squash ends");
    // R10 trap / quiesce
    trapEv[0] = 1; quiesceEv[1] = 1; step("R10 trap and quiesce");
    stallSet[2] = 1;          step("R10 trap holds over stall");
    wakeEv = '1;              step("R10 wake");
    stallClr[2] = 1;          step("R3 unblock after wake");
    // R11 stage activity
    activeMask = 2'b01; stallSet[3] = 1; step("R11 only blocked thread active");
    stallClr[3] = 1;          step("R11 back to run");
    activeMask = '1;          step("R11 all active");
    // Mixed traffic
    for (int c = 0; c < 3000; c++) begin
      randomInputs();
      step("R4 R5 R7 R8 R9 mixed traffic");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule